// File: doc/BRIEF.md
# Partial Search Tree Traversal Engine

This block walks a binary search tree of memory pages on behalf of software. Software loads a small scan table whose entries each carry a physical page number plus the table indices of a left and a right child, writes a candidate page number together with its hash into a candidate register, and then pulses a start input. The engine compares the candidate page against the page of the current node, one line at a time, and then descends to the left or right child, stops on a content match, or stops when the chosen child is absent. Table entry zero is always where a walk begins. Because the table may hold only the upper levels of a larger tree, software reloads the table with the node where the last walk stopped placed at entry zero, and starts again.

Page contents are not stored here. A separate fetch unit serves them: the engine issues one line request at a time (page number plus line index) on a valid/ready channel and takes the returned line on a second valid/ready channel. A request, once raised, stays raised and unchanged until it is accepted. The engine never has more than one request outstanding and raises no new request until the response to the previous one has been taken. It holds its response-ready high only while it waits for a response, so the fetch unit may keep a response back for as many cycles as it likes.

The outcome, a status code and the index of the last node compared, stays on the status outputs until the next start. Software polls these outputs.

Top module: `pagetree_walker`

## Requirements
- R1: After reset the status is idle (code 0), the last-node index is 0, and neither req_valid nor rsp_ready is high.
- R2: A walk starts at table entry 0. The first request of a walk carries the candidate page number at line 0, and the second request carries the page number held in entry 0 at line 0.
- R3: Each candidate/node pair is compared from line 0 upward. For each line, the candidate line is requested first and the node line second. The first line that differs decides the order, and no further lines of that pair are requested.
- R4: Two lines are ordered as unsigned numbers whose most significant byte (the top bits of the data bus) has the highest weight.
- R5: A candidate that orders below the node page moves the walk to the left child. A candidate that orders above it moves the walk to the right child.
- R6: When every line of the two pages is equal, the walk ends with status match (code 2), and the last-node index holds that node.
- R7: A chosen child index that is not below the table depth, including the all-ones NULL value, ends the walk with status no-match (code 3), and the last-node index holds the node just compared.
- R8: A walk compares at most DEPTH nodes. If a further non-NULL step would be needed after that, the walk ends with status loop error (code 4), and the last-node index holds the node just compared.
- R9: While a walk is busy (status code 1), a start pulse, a candidate write and a table write all have no effect.
- R10: The request channel holds req_valid, req_ppn and req_line stable until the request is accepted, and never raises a request while a response is owed.
- R11: A finished status and its last-node index stay unchanged until the next start, and a start is accepted in any finished state.
- R12: The hash written with the candidate appears on cand_hash_o and is not altered by a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Scan-table write strobe |
| tbl_addr | input | IDX_W | Entry to write |
| tbl_ppn | input | PPN_W | Page number for the entry |
| tbl_left | input | IDX_W | Left-child index (all ones = NULL) |
| tbl_right | input | IDX_W | Right-child index (all ones = NULL) |
| cand_we | input | 1 | Candidate register write strobe |
| cand_ppn | input | PPN_W | Candidate page number |
| cand_hash | input | HASH_W | Candidate hash value |
| start | input | 1 | Start pulse |
| status | output | 3 | 0 idle, 1 busy, 2 match, 3 no-match, 4 loop error |
| last_idx | output | IDX_W | Last node compared in the finished walk |
| cand_hash_o | output | HASH_W | Stored candidate hash |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted |
| req_ppn | output | PPN_W | Page number of requested line |
| req_line | output | LIDX_W | Line index within the page |
| rsp_valid | input | 1 | Line response valid |
| rsp_ready | output | 1 | Engine can take a response |
| rsp_data | input | LINE_W | Returned line data |

## Verification
The bench builds the engine with a four-entry table, 8-bit page numbers, 16-bit lines and two lines per page. With these values every six-bit page content, plus an aliasing bit that makes distinct page numbers share content, can be swept against each loaded tree. A four-step limit can be reached by a two-node cycle, and an out-of-range child index (5) sits beside the NULL value (7). The line contents are chosen so that a high byte and a low byte decide in opposite directions, and the second line decides only when the first is equal. Byte order, line order and early stopping therefore all change the number of requests and the end node.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    WS_IDLE  = 3'd0,
    WS_BUSY  = 3'd1,
    WS_MATCH = 3'd2,
    WS_NULL  = 3'd3,
    WS_LOOP  = 3'd4
  } walk_status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_RSP  = 2'd2
  } walk_phase_e;

endpackage

// File: rtl/pgw_scan_table.sv
module pgw_scan_table #(
  parameter int DEPTH = 8,
  parameter int PPN_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [PPN_W-1:0] wppn,
  input  logic [IDX_W-1:0] wleft,
  input  logic [IDX_W-1:0] wright,
  input  logic [IDX_W-1:0] raddr,
  output logic [PPN_W-1:0] rppn,
  output logic [IDX_W-1:0] rleft,
  output logic [IDX_W-1:0] rright
);

  logic [PPN_W-1:0] ppn_q   [DEPTH];
  logic [IDX_W-1:0] left_q  [DEPTH];
  logic [IDX_W-1:0] right_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ppn_q[e]   <= '0;
        left_q[e]  <= '1;
        right_q[e] <= '1;
      end else if (hit) begin
        ppn_q[e]   <= wppn;
        left_q[e]  <= wleft;
        right_q[e] <= wright;
      end
    end
  end

  always_comb begin
    rppn   = '0;
    rleft  = '1;
    rright = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr == IDX_W'(i)) begin
        rppn   = ppn_q[i];
        rleft  = left_q[i];
        rright = right_q[i];
      end
    end
  end

endmodule

// File: rtl/pgw_line_order.sv
module pgw_line_order #(
  parameter int LINE_W = 32
) (
  input  logic [LINE_W-1:0] cand_line,
  input  logic [LINE_W-1:0] node_line,
  output logic              below,
  output logic              above
);

  localparam int NBYTES = LINE_W / 8;

  logic [NBYTES-1:0] differs;
  logic [NBYTES-1:0] smaller;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign differs[k] = cand_line[k*8 +: 8] != node_line[k*8 +: 8];
    assign smaller[k] = cand_line[k*8 +: 8] <  node_line[k*8 +: 8];
  end

  // Higher byte lanes overwrite lower ones, so the most significant
  // differing byte settles the order.
  always_comb begin
    below = 1'b0;
    above = 1'b0;
    for (int k = 0; k < NBYTES; k++) begin
      if (differs[k]) begin
        below = smaller[k];
        above = !smaller[k];
      end
    end
  end

endmodule

// File: rtl/pgw_walk_ctrl.sv
module pgw_walk_ctrl
  import pgw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PPN_W  = 16,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 32,
  parameter int LINES  = 4,
  parameter int LIDX_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PPN_W-1:0]  cand_ppn,
  input  logic [PPN_W-1:0]  node_ppn,
  input  logic [IDX_W-1:0]  node_left,
  input  logic [IDX_W-1:0]  node_right,
  output logic [IDX_W-1:0]  cur_idx,
  input  logic              below,
  input  logic              above,
  output logic [LINE_W-1:0] held_line,
  output logic              busy,
  output walk_status_e      status,
  output logic [IDX_W-1:0]  last_idx,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PPN_W-1:0]  req_ppn,
  output logic [LIDX_W-1:0] req_line,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [LINE_W-1:0] rsp_data
);

  walk_phase_e       ph_q;
  walk_status_e      st_q;
  logic              node_side_q;
  logic [LIDX_W-1:0] line_q;
  logic [IDX_W-1:0]  cur_q;
  logic [IDX_W-1:0]  last_q;
  logic [CNT_W-1:0]  visits_q;
  logic [LINE_W-1:0] held_q;

  logic [IDX_W-1:0]  child;
  logic              child_absent;
  logic              pages_equal;
  logic              last_line;
  logic              step_cap;

  assign child        = below ? node_left : node_right;
  assign child_absent = child >= IDX_W'(DEPTH);
  assign pages_equal  = !below && !above;
  assign last_line    = line_q == LIDX_W'(LINES - 1);
  assign step_cap     = visits_q == CNT_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      st_q        <= WS_IDLE;
      node_side_q <= 1'b0;
      line_q      <= '0;
      cur_q       <= '0;
      last_q      <= '0;
      visits_q    <= '0;
      held_q      <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q        <= PH_REQ;
            st_q        <= WS_BUSY;
            node_side_q <= 1'b0;
            line_q      <= '0;
            cur_q       <= '0;
            visits_q    <= CNT_W'(1);
          end
        end
        PH_REQ: begin
          if (req_ready) ph_q <= PH_RSP;
        end
        PH_RSP: begin
          if (rsp_valid) begin
            if (!node_side_q) begin
              held_q      <= rsp_data;
              node_side_q <= 1'b1;
              ph_q        <= PH_REQ;
            end else begin
              node_side_q <= 1'b0;
              if (pages_equal && !last_line) begin
                line_q <= line_q + LIDX_W'(1);
                ph_q   <= PH_REQ;
              end else if (pages_equal) begin
                ph_q   <= PH_IDLE;
                st_q   <= WS_MATCH;
                last_q <= cur_q;
              end else if (child_absent) begin
                ph_q   <= PH_IDLE;
                st_q   <= WS_NULL;
                last_q <= cur_q;
              end else if (step_cap) begin
                ph_q   <= PH_IDLE;
                st_q   <= WS_LOOP;
                last_q <= cur_q;
              end else begin
                cur_q    <= child;
                visits_q <= visits_q + CNT_W'(1);
                line_q   <= '0;
                ph_q     <= PH_REQ;
              end
            end
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cur_idx   = cur_q;
  assign held_line = held_q;
  assign busy      = ph_q != PH_IDLE;
  assign status    = st_q;
  assign last_idx  = last_q;
  assign req_valid = ph_q == PH_REQ;
  assign req_ppn   = node_side_q ? node_ppn : cand_ppn;
  assign req_line  = line_q;
  assign rsp_ready = ph_q == PH_RSP;

endmodule

// File: rtl/pagetree_walker.sv
module pagetree_walker
  import pgw_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int PPN_W  = 16,
  parameter int LINE_W = 32,
  parameter int LINES  = 4,
  parameter int HASH_W = 32,
  localparam int IDX_W  = $clog2(DEPTH + 1),
  localparam int LIDX_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [PPN_W-1:0]  tbl_ppn,
  input  logic [IDX_W-1:0]  tbl_left,
  input  logic [IDX_W-1:0]  tbl_right,
  input  logic              cand_we,
  input  logic [PPN_W-1:0]  cand_ppn,
  input  logic [HASH_W-1:0] cand_hash,
  input  logic              start,
  output logic [2:0]        status,
  output logic [IDX_W-1:0]  last_idx,
  output logic [HASH_W-1:0] cand_hash_o,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PPN_W-1:0]  req_ppn,
  output logic [LIDX_W-1:0] req_line,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [LINE_W-1:0] rsp_data
);

  logic              busy;
  logic [PPN_W-1:0]  cand_ppn_q;
  logic [HASH_W-1:0] cand_hash_q;
  logic [IDX_W-1:0]  cur_idx;
  logic [PPN_W-1:0]  node_ppn;
  logic [IDX_W-1:0]  node_left;
  logic [IDX_W-1:0]  node_right;
  logic [LINE_W-1:0] held_line;
  logic              below;
  logic              above;
  walk_status_e      st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_ppn_q  <= '0;
      cand_hash_q <= '0;
    end else if (cand_we && !busy) begin
      cand_ppn_q  <= cand_ppn;
      cand_hash_q <= cand_hash;
    end
  end

  pgw_scan_table #(.DEPTH(DEPTH), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we && !busy),
    .waddr  (tbl_addr),
    .wppn   (tbl_ppn),
    .wleft  (tbl_left),
    .wright (tbl_right),
    .raddr  (cur_idx),
    .rppn   (node_ppn),
    .rleft  (node_left),
    .rright (node_right)
  );

  pgw_line_order #(.LINE_W(LINE_W)) u_order (
    .cand_line (held_line),
    .node_line (rsp_data),
    .below     (below),
    .above     (above)
  );

  pgw_walk_ctrl #(
    .DEPTH(DEPTH), .PPN_W(PPN_W), .IDX_W(IDX_W), .LINE_W(LINE_W),
    .LINES(LINES), .LIDX_W(LIDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cand_ppn   (cand_ppn_q),
    .node_ppn   (node_ppn),
    .node_left  (node_left),
    .node_right (node_right),
    .cur_idx    (cur_idx),
    .below      (below),
    .above      (above),
    .held_line  (held_line),
    .busy       (busy),
    .status     (st),
    .last_idx   (last_idx),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_ppn    (req_ppn),
    .req_line   (req_line),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data)
  );

  assign status      = st;
  assign cand_hash_o = cand_hash_q;

endmodule

// File: rtl/pgw_walker_checks.sv
module pgw_walker_checks #(
  parameter int DEPTH  = 8,
  parameter int PPN_W  = 16,
  parameter int IDX_W  = 4,
  parameter int LIDX_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        status,
  input logic [IDX_W-1:0]  last_idx,
  input logic              req_valid,
  input logic              req_ready,
  input logic [PPN_W-1:0]  req_ppn,
  input logic [LIDX_W-1:0] req_line,
  input logic              rsp_ready
);

  // R1: only the five defined status codes appear
  a_r1_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    status <= 3'd4);

  // R3: an accepted start leads straight to a line-0 request
  a_r3_first_req: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 3'd1) && start |=> req_valid && (req_line == '0) && (status == 3'd1));

  // R7: a finished walk names a node that exists in the table
  a_r7_last_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    (status >= 3'd2) |-> (last_idx < IDX_W'(DEPTH)));

  // R10: a stalled request is held unchanged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_ppn) && $stable(req_line));

  // R10: never a request while a response is owed
  a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready);

  // R9: the fetch channels move only during a busy walk
  a_r9_traffic_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || rsp_ready) |-> (status == 3'd1));

  // R11: a finished result holds until the next start
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status >= 3'd2) && !start |=> $stable(status) && $stable(last_idx));

endmodule

bind pagetree_walker pgw_walker_checks #(
  .DEPTH(DEPTH), .PPN_W(PPN_W), .IDX_W(IDX_W), .LIDX_W(LIDX_W)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .status    (status),
  .last_idx  (last_idx),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_ppn   (req_ppn),
  .req_line  (req_line),
  .rsp_ready (rsp_ready)
);

// File: tb/pagetree_walker_test.sv
module pagetree_walker_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int PPN_W  = 8;
  localparam int LINE_W = 16;
  localparam int LINES  = 2;
  localparam int HASH_W = 32;
  localparam int IDX_W  = 3;
  localparam int LIDX_W = 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tbl_we = 1'b0;
  logic [IDX_W-1:0]  tbl_addr = '0;
  logic [PPN_W-1:0]  tbl_ppn = '0;
  logic [IDX_W-1:0]  tbl_left = '0;
  logic [IDX_W-1:0]  tbl_right = '0;
  logic              cand_we = 1'b0;
  logic [PPN_W-1:0]  cand_ppn = '0;
  logic [HASH_W-1:0] cand_hash = '0;
  logic              start = 1'b0;
  logic [2:0]        status;
  logic [IDX_W-1:0]  last_idx;
  logic [HASH_W-1:0] cand_hash_o;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [PPN_W-1:0]  req_ppn;
  logic [LIDX_W-1:0] req_line;
  logic              rsp_valid = 1'b0;
  logic              rsp_ready;
  logic [LINE_W-1:0] rsp_data = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pagetree_walker #(
    .DEPTH(DEPTH), .PPN_W(PPN_W), .LINE_W(LINE_W), .LINES(LINES), .HASH_W(HASH_W)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_ppn(tbl_ppn),
    .tbl_left(tbl_left), .tbl_right(tbl_right),
    .cand_we(cand_we), .cand_ppn(cand_ppn), .cand_hash(cand_hash),
    .start(start), .status(status), .last_idx(last_idx), .cand_hash_o(cand_hash_o),
    .req_valid(req_valid), .req_ready(req_ready), .req_ppn(req_ppn), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  // Page content: depends on ppn bits 5..0 only, so bit 6 makes aliases.
  function automatic logic [15:0] page_line(input logic [7:0] p, input int l);
    if (l == 0) return {6'b0, p[5:4], 6'b0, p[3:2]};
    return {7'b0, p[0], 6'b0, p[1], ~p[1]};
  endfunction

  function automatic logic [31:0] page_key(input logic [7:0] p);
    return {page_line(p, 0), page_line(p, 1)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench copy of the table
  logic [7:0] m_ppn [DEPTH];
  logic [2:0] m_l   [DEPTH];
  logic [2:0] m_r   [DEPTH];

  // Fetch-unit model
  logic [15:0] lfsr = 16'hACE1;
  bit          pending = 0, rq_f = 0, rs_f = 0, hold = 0;
  logic [7:0]  p_ppn = '0, h_ppn = '0;
  logic        p_line = 1'b0, h_line = 1'b0;
  int          delay = 0;
  int          req_count = 0;
  logic [7:0]  req_log [2];

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!rst_n) begin
        pending = 0; rq_f = 0; rs_f = 0; hold = 0;
        req_ready = 1'b0; rsp_valid = 1'b0;
      end else begin
        if (rs_f) begin pending = 0; rsp_valid = 1'b0; end
        if (rq_f) begin pending = 1; delay = int'(lfsr[1:0]); end
        if (hold)
          check(req_valid && req_ppn == h_ppn && req_line == h_line,
                "R10 stalled request held", int'(req_ppn), int'(h_ppn));
        if (pending && !rsp_valid) begin
          if (delay == 0) begin
            rsp_valid = 1'b1;
            rsp_data  = page_line(p_ppn, int'(p_line));
          end else delay--;
        end
        if (pending)
          check(!req_valid, "R10 no request while response owed", int'(req_valid), 0);
        req_ready = !pending && lfsr[3];
        rq_f = req_valid && req_ready;
        if (rq_f) begin
          p_ppn = req_ppn; p_line = req_line;
          if (req_count < 2) req_log[req_count] = req_ppn;
          req_count++;
        end
        rs_f = rsp_valid && rsp_ready;
        hold = req_valid && !req_ready;
        h_ppn = req_ppn; h_line = req_line;
      end
    end
  end

  task automatic load_entry(input int idx, input logic [7:0] p, input logic [2:0] l,
                            input logic [2:0] r, input bit track);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 3'(idx); tbl_ppn = p; tbl_left = l; tbl_right = r;
    @(negedge clk);
    tbl_we = 1'b0;
    if (track) begin m_ppn[idx] = p; m_l[idx] = l; m_r[idx] = r; end
  endtask

  task automatic expect_walk(input logic [7:0] cp, output int st, output int last,
                             output int nreq);
    int cur = 0, visits = 1;
    bit done = 0;
    nreq = 0; st = 0; last = 0;
    while (!done) begin
      logic [31:0] kc = page_key(cp);
      logic [31:0] kn = page_key(m_ppn[cur]);
      int ch;
      nreq += (page_line(cp, 0) == page_line(m_ppn[cur], 0)) ? 4 : 2;
      if (kc == kn) begin st = 2; last = cur; done = 1; end
      else begin
        ch = (kc < kn) ? int'(m_l[cur]) : int'(m_r[cur]);
        if (ch >= DEPTH) begin st = 3; last = cur; done = 1; end
        else if (visits == DEPTH) begin st = 4; last = cur; done = 1; end
        else begin cur = ch; visits++; end
      end
    end
  endtask

  task automatic wait_done();
    int k = 0;
    while (status == 3'd1 && k < 5000) begin @(negedge clk); k++; end
  endtask

  task automatic walk(input logic [7:0] cp, input string tag);
    int est, elast, enreq;
    logic [31:0] h = {cp, ~cp, cp ^ 8'h5A, 8'hC3};
    @(negedge clk);
    cand_we = 1'b1; cand_ppn = cp; cand_hash = h;
    @(negedge clk);
    cand_we = 1'b0;
    req_count = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    expect_walk(cp, est, elast, enreq);
    check(int'(status) == est, {tag, " status"}, int'(status), est);
    check(int'(last_idx) == elast, {tag, " last node"}, int'(last_idx), elast);
    check(req_count == enreq, {tag, " R3 R4 line request count"}, req_count, enreq);
    check(req_log[0] == cp, "R2 first request is candidate", int'(req_log[0]), int'(cp));
    check(req_log[1] == m_ppn[0], "R2 second request is entry 0",
          int'(req_log[1]), int'(m_ppn[0]));
    check(cand_hash_o == h, "R12 hash kept", int'(cand_hash_o), int'(h));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int st0;
    logic [2:0] li0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(status == 3'd0, "R1 status idle", int'(status), 0);
    check(last_idx == '0, "R1 last index", int'(last_idx), 0);
    check(!req_valid && !rsp_ready, "R1 channels quiet", int'(req_valid), 0);
    rst_n = 1'b1;

    // Tree A: proper BST, NULL = 7. R5 R6 R7
    load_entry(0, 8'h20, 3'd1, 3'd2, 1);
    load_entry(1, 8'h10, 3'd7, 3'd3, 1);
    load_entry(2, 8'h30, 3'd7, 3'd7, 1);
    load_entry(3, 8'h19, 3'd7, 3'd7, 1);
    for (int p = 0; p < 128; p++) walk(8'(p), "R5 R6 R7 tree A");

    // R11: finished result holds, then a new start is accepted
    st0 = int'(status); li0 = last_idx;
    repeat (12) @(negedge clk);
    check(int'(status) == st0 && last_idx == li0, "R11 result held",
          int'(status), st0);
    walk(8'h19, "R11 restart from finished");

    // Tree B: two-node cycle exercises the step cap. R8
    load_entry(0, 8'h20, 3'd1, 3'd1, 1);
    load_entry(1, 8'h10, 3'd0, 3'd0, 1);
    for (int p = 0; p < 64; p++) walk(8'(p), "R8 tree B");

    // Tree C: child index 5 is out of range and acts as NULL. R7
    load_entry(0, 8'h20, 3'd5, 3'd6, 1);
    for (int p = 0; p < 64; p += 3) walk(8'(p), "R7 tree C");

    // R9: writes and start during a busy walk have no effect
    load_entry(0, 8'h20, 3'd1, 3'd2, 1);
    load_entry(1, 8'h10, 3'd7, 3'd3, 1);
    load_entry(2, 8'h30, 3'd7, 3'd7, 1);
    load_entry(3, 8'h19, 3'd7, 3'd7, 1);
    walk(8'h33, "R9 baseline");
    @(negedge clk);
    cand_we = 1'b1; cand_ppn = 8'h33; cand_hash = 32'h1234_5678;
    @(negedge clk);
    cand_we = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(status == 3'd1, "R9 busy after start", int'(status), 1);
    start = 1'b1; cand_we = 1'b1; cand_ppn = 8'h20; cand_hash = 32'hDEAD_BEEF;
    tbl_we = 1'b1; tbl_addr = 3'd0; tbl_ppn = 8'h33; tbl_left = 3'd7; tbl_right = 3'd7;
    @(negedge clk);
    start = 1'b0; cand_we = 1'b0; tbl_we = 1'b0;
    wait_done();
    check(status == 3'd3, "R9 result unchanged by busy writes", int'(status), 3);
    check(last_idx == 3'd2, "R9 last node unchanged", int'(last_idx), 2);
    check(cand_hash_o == 32'h1234_5678, "R9 R12 hash not overwritten while busy",
          int'(cand_hash_o), 32'h1234_5678);
    @(negedge clk);
    req_count = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(status == 3'd3 && last_idx == 3'd2, "R9 table write while busy dropped",
          int'(status), 3);
    check(req_log[1] == 8'h20, "R9 entry 0 page unchanged", int'(req_log[1]), 32);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule